// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This controller gathers interrupt requests from a software trap, from groups of external pins and from the status flags of on-chip peripherals. It folds them onto twelve levels, numbered 0 to 11. Level 0 is the most urgent and level 11 the least. Each cycle it picks the most urgent pending level. It then presents a request strobe to the CPU, together with the level number and the 16-bit address of that level's two-byte vector slot.

The presented level and vector stay frozen until the CPU acknowledges them. The strobe then drops for one cycle before the next choice is made. Sources stay pending until software clears them at their origin. The trap is the exception: the acknowledge of level 0 clears it.

A separate combinational wake output lets a halted core restart without a running clock. Only enabled external pins can raise it. Trap and peripheral requests never do.

Top module: `vic_top`

## Requirements
- R1: While reset is held and right after it, `irq` is 0, `irq_level` is 0 and `irq_vector` is FFFEh, the reset slot.
- R2: A level 1..11 requests when any bit of its slice of `src_flag` is 1 together with the same bit of `src_en`. The slices in bit order are: level 1 bit 0, level 2 bits 4:1, level 3 bits 6:5, level 4 bits 11:7, level 5 bits 13:12, level 6 bits 18:14, level 7 bits 20:19, level 8 bits 25:21, level 9 bits 27:26, level 10 bits 29:28, level 11 bits 32:30. A flag whose enable bit is 0 has no effect.
- R3: When several levels are pending, the lowest-numbered one is presented. Repeated acknowledges therefore serve them in ascending order.
- R4: The presented vector is FFFCh minus twice the level number, so level 0 gives FFFCh and level 11 gives FFE6h.
- R5: `irq` rises on the first clock edge at which a request is seen while `irq` is low. While `irq` is high and `int_ack` is low, `irq_level` and `irq_vector` stay unchanged, even when a more urgent request arrives.
- R6: On an edge with `irq` and `int_ack` both high, `irq` falls. It is re-evaluated at the following edge.
- R7: A `trap_set` pulse makes level 0 pending from the next edge on, and level 0 is not gated by `gie`. It is cleared only by an acknowledge while level 0 is presented. If `trap_set` arrives in that same cycle, the trap stays pending.
- R8: With `gie` low, levels 1..11 are never presented.
- R9: `wake` is combinational and is high exactly when some enabled pin of levels 1, 2, 9 or 10 is active. It ignores `gie`, the clock, the trap and all peripheral flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gie | input | 1 | Global enable for levels 1..11 |
| trap_set | input | 1 | Software trap request pulse |
| int_ack | input | 1 | CPU acknowledge of the presented request |
| src_flag | input | 33 | Source flags, sliced per level as in R2 |
| src_en | input | 33 | Per-bit enables matching `src_flag` |
| irq | output | 1 | Interrupt request strobe to the CPU |
| irq_level | output | 4 | Presented level number |
| irq_vector | output | 16 | Address of the presented vector slot |
| wake | output | 1 | Combinational wake-up from halt |

## Verification
An acknowledge that clears the trap can land in the same cycle as a new `trap_set` pulse. The bench provokes this by driving both on one falling edge while level 0 is presented. It judges the result by whether level 0 comes back after the one-cycle gap. A second collision is a more urgent request arriving while an older level is held. This is judged by the held level staying put until the acknowledge and the newcomer appearing right after it.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NUM_LVL = 12;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int VEC_W   = 16;
    localparam logic [VEC_W-1:0] RST_VEC  = 16'hFFFE;
    localparam logic [VEC_W-1:0] BASE_VEC = 16'hFFFC;

    // number of source bits per level; level 0 (trap) has none
    function automatic int lvl_width(input int n);
        case (n)
            1:       return 1;
            2:       return 4;
            3, 5, 7: return 2;
            4, 6, 8: return 5;
            9, 10:   return 2;
            11:      return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int lvl_offset(input int n);
        int s;
        s = 0;
        for (int k = 1; k < n; k++) s += lvl_width(k);
        return s;
    endfunction

    localparam int NSRC = lvl_offset(NUM_LVL);

    // levels fed by external pins may wake the core
    function automatic bit lvl_wakes(input int n);
        return (n == 1) || (n == 2) || (n == 9) || (n == 10);
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [LVL_W-1:0] l);
        return BASE_VEC - (VEC_W'(l) << 1);
    endfunction

    typedef struct packed {
        logic              trap_pend;
        logic              irq;
        logic [LVL_W-1:0]  lvl;
        logic [VEC_W-1:0]  vec;
    } vic_state_t;
endpackage

// File: rtl/vic_gather.sv
module vic_gather
    import vic_pkg::*;
(
    input  logic [NSRC-1:0]    src_flag,
    input  logic [NSRC-1:0]    src_en,
    output logic [NUM_LVL-1:1] lvl_req
);
    for (genvar n = 1; n < NUM_LVL; n++) begin : g_lvl
        localparam int OFF = lvl_offset(n);
        localparam int W   = lvl_width(n);
        assign lvl_req[n] = |(src_flag[OFF +: W] & src_en[OFF +: W]);
    end
endmodule

// File: rtl/vic_wake.sv
module vic_wake
    import vic_pkg::*;
(
    input  logic [NSRC-1:0] src_flag,
    input  logic [NSRC-1:0] src_en,
    output logic            wake
);
    logic [NUM_LVL-1:0] part;
    assign part[0] = 1'b0;
    for (genvar n = 1; n < NUM_LVL; n++) begin : g_w
        localparam int OFF = lvl_offset(n);
        localparam int W   = lvl_width(n);
        if (lvl_wakes(n)) begin : g_pin
            assign part[n] = |(src_flag[OFF +: W] & src_en[OFF +: W]);
        end else begin : g_none
            assign part[n] = 1'b0;
        end
    end
    assign wake = |part;
endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
(
    input  logic [NUM_LVL-1:0] req,
    output logic               valid,
    output logic [LVL_W-1:0]   lvl
);
    always_comb begin
        valid = |req;
        lvl   = '0;
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (req[i]) lvl = LVL_W'(i);
        end
    end
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gie,
    input  logic                trap_set,
    input  logic                int_ack,
    input  logic [NSRC-1:0]     src_flag,
    input  logic [NSRC-1:0]     src_en,
    output logic                irq,
    output logic [LVL_W-1:0]    irq_level,
    output logic [VEC_W-1:0]    irq_vector,
    output logic                wake
);
    vic_state_t          q, d;
    logic [NUM_LVL-1:1]  periph_req;
    logic [NUM_LVL-1:0]  eff_req;
    logic                sel_valid;
    logic [LVL_W-1:0]    sel_lvl;

    vic_gather u_gather (
        .src_flag (src_flag),
        .src_en   (src_en),
        .lvl_req  (periph_req)
    );

    vic_wake u_wake (
        .src_flag (src_flag),
        .src_en   (src_en),
        .wake     (wake)
    );

    assign eff_req = {periph_req & {(NUM_LVL-1){gie}}, q.trap_pend};

    vic_prio u_prio (
        .req   (eff_req),
        .valid (sel_valid),
        .lvl   (sel_lvl)
    );

    always_comb begin
        d = q;
        if (q.irq && int_ack && (q.lvl == '0)) d.trap_pend = 1'b0;
        if (trap_set)                          d.trap_pend = 1'b1;
        if (q.irq) begin
            if (int_ack) d.irq = 1'b0;
        end else if (sel_valid) begin
            d.irq = 1'b1;
            d.lvl = sel_lvl;
            d.vec = vec_of(sel_lvl);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.trap_pend <= 1'b0;
            q.irq       <= 1'b0;
            q.lvl       <= '0;
            q.vec       <= RST_VEC;
        end else begin
            q <= d;
        end
    end

    assign irq        = q.irq;
    assign irq_level  = q.lvl;
    assign irq_vector = q.vec;
endmodule

// File: rtl/vic_top_chk.sv
module vic_top_chk
    import vic_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                gie,
    input logic                trap_set,
    input logic                int_ack,
    input logic [NSRC-1:0]     src_flag,
    input logic [NSRC-1:0]     src_en,
    input logic                irq,
    input logic [LVL_W-1:0]    irq_level,
    input logic [VEC_W-1:0]    irq_vector,
    input logic                wake
);
    function automatic logic [NSRC-1:0] pin_mask();
        logic [NSRC-1:0] m;
        m = '0;
        for (int n = 1; n < NUM_LVL; n++)
            if (lvl_wakes(n))
                for (int b = 0; b < lvl_width(n); b++) m[lvl_offset(n) + b] = 1'b1;
        return m;
    endfunction
    localparam logic [NSRC-1:0] PIN_MASK = pin_mask();

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !int_ack) |=> (irq && $stable(irq_level) && $stable(irq_vector)));

    a_r6_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && int_ack) |=> !irq);

    a_r8_gie_block: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && !$past(gie)) |-> (irq_level == '0));

    a_r4_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vector == 16'hFFFC - {irq_level, 1'b0}));

    a_r9_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_flag & src_en & PIN_MASK) == '0) |-> !wake);

    a_r7_trap_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && int_ack && trap_set && irq_level == '0) |=> !irq ##1 (irq && irq_level == '0));
endmodule

bind vic_top vic_top_chk u_chk (.*);

// File: tb/vic_top_test.sv
module vic_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gie = 1'b1;
    logic        trap_set = 1'b0;
    logic        int_ack = 1'b0;
    logic [32:0] src_flag = '0;
    logic [32:0] src_en = '0;
    logic        irq;
    logic [3:0]  irq_level;
    logic [15:0] irq_vector;
    logic        wake;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    vic_top uut (
        .clk(clk), .rst_n(rst_n), .gie(gie), .trap_set(trap_set), .int_ack(int_ack),
        .src_flag(src_flag), .src_en(src_en), .irq(irq), .irq_level(irq_level),
        .irq_vector(irq_vector), .wake(wake)
    );

    localparam int BW [12] = '{0, 1, 4, 2, 5, 2, 5, 2, 5, 2, 2, 3};

    function automatic int b_off(input int n);
        int s = 0;
        for (int k = 1; k < n; k++) s += BW[k];
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_lvl(input int n, input bit f, input bit e);
        for (int b = 0; b < BW[n]; b++) begin
            src_flag[b_off(n) + b] = f;
            src_en[b_off(n) + b]   = e;
        end
    endtask

    task automatic ack_gap();
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(irq_level == 4'd0, "R1 level", irq_level, 0);
        chk(irq_vector == 16'hFFFE, "R1 vector", irq_vector, 16'hFFFE);
    endtask

    task automatic t_levels();
        for (int n = 1; n < 12; n++) begin
            @(negedge clk);
            set_lvl(n, 1'b0, 1'b1);
            src_flag[b_off(n) + BW[n] - 1] = 1'b1;
            #1;
            chk(wake == (n == 1 || n == 2 || n == 9 || n == 10), "R9 wake per level", wake, n);
            @(negedge clk);
            chk(irq == 1'b1, "R2 irq per level", irq, 1);
            chk(irq_level == 4'(n), "R2 level", irq_level, n);
            chk(irq_vector == 16'hFFFC - 16'(2 * n), "R4 vector", irq_vector, 16'hFFFC - 2 * n);
            set_lvl(n, 1'b0, 1'b0);
            ack_gap();
            @(negedge clk);
            chk(irq == 1'b0, "R6 idle after clear", irq, 0);
        end
    endtask

    task automatic t_mask();
        @(negedge clk);
        src_flag[b_off(4) + 2] = 1'b1;
        src_flag[b_off(2) + 1] = 1'b1;
        #1;
        chk(wake == 1'b0, "R9 disabled pin", wake, 0);
        repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R2 disabled flag", irq, 0);
        src_en[b_off(4) + 2] = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1 && irq_level == 4'd4, "R2 enabled flag", irq_level, 4);
        src_flag = '0; src_en = '0;
        ack_gap();
        @(negedge clk);
    endtask

    task automatic t_prio();
        @(negedge clk);
        trap_set = 1'b1;
        @(negedge clk);
        trap_set = 1'b0;
        for (int n = 1; n < 12; n++) set_lvl(n, 1'b1, 1'b1);
        @(negedge clk);
        for (int e = 0; e < 12; e++) begin
            chk(irq == 1'b1, "R3 irq in order", irq, 1);
            chk(irq_level == 4'(e), "R3 order", irq_level, e);
            if (e > 0) set_lvl(e, 1'b0, 1'b0);
            ack_gap();
            chk(irq == 1'b0, "R6 gap", irq, 0);
            @(negedge clk);
        end
        chk(irq == 1'b0, "R7 trap cleared", irq, 0);
    endtask

    task automatic t_gie();
        @(negedge clk);
        gie = 1'b0;
        set_lvl(3, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        chk(irq == 1'b0, "R8 gated", irq, 0);
        trap_set = 1'b1;
        @(negedge clk);
        trap_set = 1'b0;
        @(negedge clk);
        chk(irq == 1'b1 && irq_level == 4'd0, "R7 trap non-maskable", irq_level, 0);
        ack_gap();
        repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R8 still gated", irq, 0);
        gie = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1 && irq_level == 4'd3, "R8 released", irq_level, 3);
        set_lvl(3, 1'b0, 1'b0);
        ack_gap();
        @(negedge clk);
    endtask

    task automatic t_hold();
        @(negedge clk);
        set_lvl(7, 1'b1, 1'b1);
        @(negedge clk);
        chk(irq_level == 4'd7, "R5 first", irq_level, 7);
        set_lvl(2, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        chk(irq == 1'b1 && irq_level == 4'd7, "R5 held", irq_level, 7);
        chk(irq_vector == 16'hFFEE, "R5 vector held", irq_vector, 16'hFFEE);
        ack_gap();
        chk(irq == 1'b0, "R6 drop", irq, 0);
        @(negedge clk);
        chk(irq == 1'b1 && irq_level == 4'd2, "R6 reselect", irq_level, 2);
        src_flag = '0; src_en = '0;
        ack_gap();
        @(negedge clk);
    endtask

    task automatic t_collide();
        @(negedge clk);
        trap_set = 1'b1;
        @(negedge clk);
        trap_set = 1'b0;
        @(negedge clk);
        chk(irq == 1'b1 && irq_level == 4'd0, "R7 trap shown", irq_level, 0);
        int_ack = 1'b1; trap_set = 1'b1;
        @(negedge clk);
        int_ack = 1'b0; trap_set = 1'b0;
        chk(irq == 1'b0, "R7 gap", irq, 0);
        @(negedge clk);
        chk(irq == 1'b1 && irq_level == 4'd0, "R7 set wins", irq_level, 0);
        ack_gap();
        repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R7 cleared", irq, 0);
    endtask

    task automatic t_wake();
        @(negedge clk);
        gie = 1'b0;
        set_lvl(10, 1'b1, 1'b1);
        #1;
        chk(wake == 1'b1, "R9 wake without gie", wake, 1);
        set_lvl(10, 1'b0, 1'b0);
        set_lvl(6, 1'b1, 1'b1);
        trap_set = 1'b1;
        #1;
        chk(wake == 1'b0, "R9 peripheral and trap", wake, 0);
        @(negedge clk);
        trap_set = 1'b0;
        set_lvl(6, 1'b0, 1'b0);
        gie = 1'b1;
        @(negedge clk);
        ack_gap();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_levels();
        t_mask();
        t_prio();
        t_gie();
        t_hold();
        t_collide();
        t_wake();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule